// File: doc/BRIEF.md
# Five-Stage Load/Store Pipeline Core

This block is a small in-order core of 32-bit words. It runs a minimal instruction set: a word load, a word store and a register-register add. Each instruction passes through five stages in order: fetch, decode with register read, execute (address or sum), memory access and write-back. A pipeline register separates each pair of stages. Each stage works on a different instruction in every clock. Control is decoded once, in decode. It then travels with its instruction, grouped by the stage that uses it, so a register holds only what the later stages still need. The destination index is carried all the way to write-back.

The instruction store, the data store and the 32-entry register file are internal arrays. The instruction store is filled through a load port while reset is held. The data store can be given initial words the same way. The core has no hazard detection and no forwarding, so programs must keep dependent instructions at least three slots apart, using no-ops. The core has two result streams: a register write-back stream and a store stream. Both carry only a valid flag. No ready is taken, because the pipeline never stalls, so a consumer must accept every beat in the cycle it is shown.

Top module: `lsp_core`

## Requirements
- R1: Fetch starts at byte address 0 when reset is released and reads one word per clock, adding 4 to the PC each time. The instruction in slot s (byte address 4*s) puts its write-back beat on the outputs s+4 clocks after the first clock edge without reset, and its store beat s+3 clocks after that edge.
- R2: A load (bits [31:26] = 0x23, base in [25:21], destination in [20:16], displacement in [15:0]) writes the data word at the effective address into the destination register. The write-back beat shows the destination index and that word.
- R3: The effective address is the base register value plus the displacement sign-extended to 32 bits, so a negative displacement gives a lower address.
- R4: A store (bits [31:26] = 0x2B, fields as for the load, data register in [20:16]) writes that register's value to the data word at the effective address. It shows a store beat with the address and data, and it produces no write-back beat.
- R5: An add (bits [31:26] = 0, bits [5:0] = 0x20, sources in [25:21] and [20:16], destination in [15:11]) writes the 32-bit wrapping sum of the two sources to the destination.
- R6: A write to register 0 has no effect and shows no write-back beat, and register 0 always reads as zero.
- R7: A register written in write-back is seen by a decode-stage read in the same clock, so a reader three slots after its writer gets the new value.
- R8: The all-zero word, any other opcode, and opcode 0 with any function code other than 0x20 write no register and no data word.
- R9: A synchronous active-high reset clears the PC to 0 and clears the control of every pipeline register, so no write-back or store beat appears while reset is held or before the first instruction reaches the matching stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write one instruction word into the instruction store |
| prog_addr | input | IAW | Word index of the instruction store |
| prog_data | input | 32 | Instruction word |
| dinit_we | input | 1 | Write one initial word into the data store |
| dinit_addr | input | DAW | Word index of the data store |
| dinit_data | input | 32 | Initial data word |
| wb_valid | output | 1 | Register write-back beat |
| wb_idx | output | 5 | Destination register of the beat |
| wb_data | output | 32 | Value written |
| st_valid | output | 1 | Store beat (memory stage) |
| st_addr | output | 32 | Effective byte address of the store |
| st_data | output | 32 | Stored word |

## Verification
An instruction in slot s shows its write-back beat exactly s+4 clocks after the first clock edge without reset. Its store beat appears at s+3 clocks. The bench counts edges from that first edge, builds the program, and from its own model of the register file and data store works out each beat's expected clock, index, address and data. It then compares every beat at the falling edge against the next expected entry, clock number included. A beat that shows up early, late or with no matching entry fails. So does any expected beat still left over once the program has drained.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int NREG = 32;

  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h20;

  // execute-stage control: second operand is the immediate (address) or rt (add)
  typedef struct packed {
    logic use_imm;
  } ex_ctrl_t;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_wr;
    logic from_mem;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [XLEN-1:0] insn);
    ctrl_t c;
    c = '0;
    unique case (insn[31:26])
      OP_LOAD: begin
        c.ex.use_imm  = 1'b1;
        c.mem.rd_en   = 1'b1;
        c.wb.reg_wr   = 1'b1;
        c.wb.from_mem = 1'b1;
      end
      OP_STORE: begin
        c.ex.use_imm = 1'b1;
        c.mem.wr_en  = 1'b1;
      end
      OP_RTYPE: begin
        if (insn[5:0] == FN_ADD) c.wb.reg_wr = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lsp_fetch.sv
module lsp_fetch
  import lsp_pkg::*;
#(
  parameter int IMEM_DEPTH = 128,
  localparam int IAW = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [XLEN-1:0] prog_data,
  output logic [XLEN-1:0] ifid_insn
);
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] pc;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      ifid_insn <= '0;
    end else begin
      pc        <= pc + XLEN'(4);
      ifid_insn <= imem[pc[IAW+1:2]];
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(pc) + XLEN'(4)); // R1
  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> (pc == '0 && ifid_insn == '0)); // R9
endmodule

// File: rtl/lsp_decode.sv
module lsp_decode
  import lsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] ifid_insn,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  output ctrl_t           idex_ctrl,
  output logic [XLEN-1:0] idex_a,
  output logic [XLEN-1:0] idex_b,
  output logic [XLEN-1:0] idex_imm,
  output logic [RIDX-1:0] idex_dst
);
  logic [XLEN-1:0] regs [NREG];
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx;
  logic [XLEN-1:0] rs_val, rt_val;
  ctrl_t           dec;

  assign regs[0] = '0;
  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= '0;
      else if (wr_en && wr_idx == RIDX'(g))     regs[g] <= wr_data;
    end
  end

  function automatic logic [XLEN-1:0] rd_port(input logic [RIDX-1:0] idx,
                                               input logic [XLEN-1:0] arr_val,
                                               input logic we, input logic [RIDX-1:0] widx,
                                               input logic [XLEN-1:0] wdat);
    if (idx == '0)                  return '0;
    else if (we && widx == idx)     return wdat;
    else                            return arr_val;
  endfunction

  assign rs_idx = ifid_insn[25:21];
  assign rt_idx = ifid_insn[20:16];
  assign rd_idx = ifid_insn[15:11];
  assign rs_val = rd_port(rs_idx, regs[rs_idx], wr_en, wr_idx, wr_data);
  assign rt_val = rd_port(rt_idx, regs[rt_idx], wr_en, wr_idx, wr_data);
  assign dec    = decode_ctrl(ifid_insn);

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_ctrl <= '0;
    end else begin
      idex_ctrl <= dec;
    end
    idex_a   <= rs_val;
    idex_b   <= rt_val;
    idex_imm <= {{(XLEN-16){ifid_insn[15]}}, ifid_insn[15:0]};
    idex_dst <= dec.wb.from_mem ? rt_idx : rd_idx;
  end

  AST_BUBBLE_ID: assert property (@(posedge clk)
    rst |=> (!idex_ctrl.wb.reg_wr && !idex_ctrl.mem.wr_en)); // R9
  AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
    (ifid_insn[25:21] == '0) |=> idex_a == '0); // R6
endmodule

// File: rtl/lsp_execute.sv
module lsp_execute
  import lsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           idex_ctrl,
  input  logic [XLEN-1:0] idex_a,
  input  logic [XLEN-1:0] idex_b,
  input  logic [XLEN-1:0] idex_imm,
  input  logic [RIDX-1:0] idex_dst,
  output mem_ctrl_t       exmem_mem,
  output wb_ctrl_t        exmem_wb,
  output logic [XLEN-1:0] exmem_res,
  output logic [XLEN-1:0] exmem_sdata,
  output logic [RIDX-1:0] exmem_dst
);
  logic [XLEN-1:0] opnd2;
  logic [XLEN-1:0] sum;

  assign opnd2 = idex_ctrl.ex.use_imm ? idex_imm : idex_b;
  assign sum   = idex_a + opnd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_mem <= '0;
      exmem_wb  <= '0;
    end else begin
      exmem_mem <= idex_ctrl.mem;
      exmem_wb  <= idex_ctrl.wb;
    end
    exmem_res   <= sum;
    exmem_sdata <= idex_b;
    exmem_dst   <= idex_dst;
  end

  AST_BUBBLE_EX: assert property (@(posedge clk)
    rst |=> (exmem_mem == '0 && exmem_wb == '0)); // R9
endmodule

// File: rtl/lsp_memory.sv
module lsp_memory
  import lsp_pkg::*;
#(
  parameter int DMEM_DEPTH = 64,
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dinit_we,
  input  logic [DAW-1:0]  dinit_addr,
  input  logic [XLEN-1:0] dinit_data,
  input  mem_ctrl_t       exmem_mem,
  input  wb_ctrl_t        exmem_wb,
  input  logic [XLEN-1:0] exmem_res,
  input  logic [XLEN-1:0] exmem_sdata,
  input  logic [RIDX-1:0] exmem_dst,
  output wb_ctrl_t        memwb_wb,
  output logic [XLEN-1:0] memwb_val,
  output logic [RIDX-1:0] memwb_dst
);
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [DAW-1:0]  widx;

  assign widx = exmem_res[DAW+1:2];

  always_ff @(posedge clk) begin
    if (exmem_mem.wr_en)  dmem[widx]       <= exmem_sdata;
    else if (dinit_we)    dmem[dinit_addr] <= dinit_data;
  end

  always_ff @(posedge clk) begin
    if (rst) memwb_wb <= '0;
    else     memwb_wb <= exmem_wb;
    memwb_val <= exmem_wb.from_mem ? dmem[widx] : exmem_res;
    memwb_dst <= exmem_dst;
  end

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    exmem_mem.wr_en |=> !memwb_wb.reg_wr); // R4
  AST_LOAD_TO_WB: assert property (@(posedge clk) disable iff (rst)
    exmem_mem.rd_en |=> (memwb_wb.reg_wr && memwb_wb.from_mem)); // R2
endmodule

// File: rtl/lsp_core.sv
module lsp_core
  import lsp_pkg::*;
#(
  parameter int IMEM_DEPTH = 128,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [31:0]     prog_data,
  input  logic            dinit_we,
  input  logic [DAW-1:0]  dinit_addr,
  input  logic [31:0]     dinit_data,
  output logic            wb_valid,
  output logic [4:0]      wb_idx,
  output logic [31:0]     wb_data,
  output logic            st_valid,
  output logic [31:0]     st_addr,
  output logic [31:0]     st_data
);
  logic [XLEN-1:0] ifid_insn;
  ctrl_t           idex_ctrl;
  logic [XLEN-1:0] idex_a, idex_b, idex_imm;
  logic [RIDX-1:0] idex_dst;
  mem_ctrl_t       exmem_mem;
  wb_ctrl_t        exmem_wb;
  logic [XLEN-1:0] exmem_res, exmem_sdata;
  logic [RIDX-1:0] exmem_dst;
  wb_ctrl_t        memwb_wb;
  logic [XLEN-1:0] memwb_val;
  logic [RIDX-1:0] memwb_dst;
  logic            rf_we;

  lsp_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
    .clk, .rst, .prog_we, .prog_addr, .prog_data, .ifid_insn
  );

  lsp_decode u_decode (
    .clk, .rst, .ifid_insn,
    .wr_en(rf_we), .wr_idx(memwb_dst), .wr_data(memwb_val),
    .idex_ctrl, .idex_a, .idex_b, .idex_imm, .idex_dst
  );

  lsp_execute u_exec (
    .clk, .rst, .idex_ctrl, .idex_a, .idex_b, .idex_imm, .idex_dst,
    .exmem_mem, .exmem_wb, .exmem_res, .exmem_sdata, .exmem_dst
  );

  lsp_memory #(.DMEM_DEPTH(DMEM_DEPTH)) u_mem (
    .clk, .rst, .dinit_we, .dinit_addr, .dinit_data,
    .exmem_mem, .exmem_wb, .exmem_res, .exmem_sdata, .exmem_dst,
    .memwb_wb, .memwb_val, .memwb_dst
  );

  assign rf_we    = memwb_wb.reg_wr && (memwb_dst != '0);
  assign wb_valid = rf_we;
  assign wb_idx   = memwb_dst;
  assign wb_data  = memwb_val;
  assign st_valid = exmem_mem.wr_en;
  assign st_addr  = exmem_res;
  assign st_data  = exmem_sdata;

  AST_WB_AFTER_EX: assert property (@(posedge clk) disable iff (rst)
    (exmem_wb.reg_wr && exmem_dst != '0) |=> wb_valid); // R2
  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    rst |=> (!st_valid)); // R9
endmodule

// File: tb/lsp_core_tb.sv
module lsp_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDEPTH = 256;
  localparam int DDEPTH = 64;
  localparam int MAXE = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic        dinit_we = 1'b0;
  logic [5:0]  dinit_addr = '0;
  logic [31:0] dinit_data = '0;
  logic        wb_valid, st_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data, st_addr, st_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsp_core #(.IMEM_DEPTH(IDEPTH), .DMEM_DEPTH(DDEPTH)) dut_i (
    .clk, .rst, .prog_we, .prog_addr, .prog_data,
    .dinit_we, .dinit_addr, .dinit_data,
    .wb_valid, .wb_idx, .wb_data, .st_valid, .st_addr, .st_data
  );

  int nchk = 0, nfail = 0;
  logic [31:0] prog [IDEPTH];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DDEPTH];
  int nslot = 0;
  int nwb = 0, nst = 0, wi = 0, si = 0;
  int    ewb_cyc [MAXE]; logic [4:0] ewb_idx [MAXE]; logic [31:0] ewb_dat [MAXE]; string ewb_req [MAXE];
  int    est_cyc [MAXE]; logic [31:0] est_adr [MAXE]; logic [31:0] est_dat [MAXE];
  int cyc = 0;
  bit running = 0;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[nslot] = w; nslot++;
    prog[nslot] = 32'h0; nslot++;
    prog[nslot] = 32'h0; nslot++;
  endtask

  task automatic do_lw(input int rt, input int rs, input logic [15:0] imm, input string req);
    logic [31:0] ea;
    ea = mreg[rs] + sx(imm);
    if (rt != 0) begin
      ewb_cyc[nwb] = nslot + 4; ewb_idx[nwb] = 5'(rt);
      ewb_dat[nwb] = mdm[ea[7:2]]; ewb_req[nwb] = req; nwb++;
      mreg[rt] = mdm[ea[7:2]];
    end
    emit({6'h23, 5'(rs), 5'(rt), imm});
  endtask

  task automatic do_sw(input int rt, input int rs, input logic [15:0] imm);
    logic [31:0] ea;
    ea = mreg[rs] + sx(imm);
    est_cyc[nst] = nslot + 3; est_adr[nst] = ea; est_dat[nst] = mreg[rt]; nst++;
    mdm[ea[7:2]] = mreg[rt];
    emit({6'h2B, 5'(rs), 5'(rt), imm});
  endtask

  task automatic do_add(input int rd, input int rs, input int rt, input string req);
    if (rd != 0) begin
      ewb_cyc[nwb] = nslot + 4; ewb_idx[nwb] = 5'(rd);
      ewb_dat[nwb] = mreg[rs] + mreg[rt]; ewb_req[nwb] = req; nwb++;
      mreg[rd] = mreg[rs] + mreg[rt];
    end
    emit({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20});
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // cycle counter: edges since the first edge with reset low
  always @(posedge clk) if (running) cyc <= cyc + 1;

  // beat monitor at the falling edge
  always @(negedge clk) begin
    if (running) begin
      if (wb_valid) begin
        if (wi < nwb) begin
          chk(cyc == ewb_cyc[wi], {ewb_req[wi], "/R1 wb timing"}, 32'(cyc), 32'(ewb_cyc[wi]));
          chk(wb_idx == ewb_idx[wi], {ewb_req[wi], " wb index"}, 32'(wb_idx), 32'(ewb_idx[wi]));
          chk(wb_data == ewb_dat[wi], {ewb_req[wi], " wb data"}, wb_data, ewb_dat[wi]);
          wi++;
        end else chk(1'b0, "R8 unexpected wb", {27'd0, wb_idx}, 32'd0);
      end
      if (st_valid) begin
        if (si < nst) begin
          chk(cyc == est_cyc[si], "R4/R1 store timing", 32'(cyc), 32'(est_cyc[si]));
          chk(st_addr == est_adr[si], "R4/R3 store address", st_addr, est_adr[si]);
          chk(st_data == est_dat[si], "R4 store data", st_data, est_dat[si]);
          si++;
        end else chk(1'b0, "R8 unexpected store", st_addr, 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < IDEPTH; i++) prog[i] = '0;
    for (int w = 0; w < DDEPTH; w++) mdm[w] = 32'h9E37_79B9 * 32'(w + 1);
    mdm[1] = 32'd40;

    // R2 sweep of loads from fixed addresses
    for (int i = 2; i <= 15; i++) do_lw(i, 0, 16'(4 * i), "R2");
    do_lw(1, 0, 16'd4, "R2");
    do_lw(16, 1, 16'hFFF8, "R3/R7");   // reads r1 three slots after its write
    do_lw(17, 1, 16'hFFD8, "R3");
    // R5 sweep of adds (wrapping sums)
    for (int i = 2; i <= 13; i++) do_add(19 + (i - 2), i, i + 1, "R5");
    do_add(0, 2, 3, "R6");
    do_add(31, 0, 4, "R6");
    do_lw(0, 0, 16'd8, "R6");
    emit(32'h0);                        // R8 all-zero word
    emit(32'hFC00_0000 | {5'd2, 5'd3, 16'd0});   // R8 unknown opcode
    emit({6'h00, 5'd2, 5'd3, 5'd9, 5'd0, 6'h21}); // R8 other function code
    for (int i = 19; i <= 26; i++) do_sw(i, 0, 16'(4 * (i + 20)));
    do_sw(2, 1, 16'hFFFC);
    do_lw(3, 0, 16'd156, "R4");
    do_lw(5, 1, 16'hFFFC, "R4/R3");
    do_add(6, 9, 0, "R8");              // r9 untouched by the 0x21 word

    // load with reset held
    @(negedge clk);
    for (int i = 0; i < IDEPTH; i++) begin
      prog_we = 1'b1; prog_addr = 8'(i); prog_data = prog[i];
      if (i < DDEPTH) begin
        dinit_we = 1'b1; dinit_addr = 6'(i);
        dinit_data = 32'h9E37_79B9 * 32'(i + 1);
        if (i == 1) dinit_data = 32'd40;
      end else dinit_we = 1'b0;
      @(negedge clk);
      chk(!wb_valid && !st_valid, "R9 idle in reset", {30'd0, wb_valid, st_valid}, 32'd0);
    end
    prog_we = 1'b0; dinit_we = 1'b0;
    rst = 1'b0;
    running = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!wb_valid && !st_valid, "R9 bubbles after reset", {30'd0, wb_valid, st_valid}, 32'd0);
    end
    wait (cyc >= nslot + 8);
    @(negedge clk);
    chk(wi == nwb, "R1 all write-backs seen", 32'(wi), 32'(nwb));
    chk(si == nst, "R4 all stores seen", 32'(si), 32'(nst));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule